// File: doc/BRIEF.md
# Quad-Data-Rate SRAM Behavioural Model

This block is a synthesizable model of a quad-data-rate static RAM. It has a read data port and a write data port, and each port moves one word on every edge of a clock. A pair of single-ended clocks drives it: `clk_k_i` and its complement `clk_kb_i`, which runs 180 degrees out of phase. A read command and a write command are each sampled on the rising edge of `clk_k_i`, and both may arrive in the same cycle. Every command moves a burst of `BURST` words (two or four). Even beats travel in the half-cycle that opens on the rising edge of `clk_k_i`, and odd beats in the half-cycle that opens on the rising edge of `clk_kb_i`.

The array is split into `BURST` banks. Beat `j` of a burst lives in bank `j`, and every bank is indexed by the same command address. The address port therefore has `log2(DEPTH/BURST)` bits: a longer burst gives fewer address bits and more, shallower banks. Active-low byte enables mask 9-bit lanes of each incoming word. Read data returns `RD_LAT` cycles after the command, together with a valid strobe and two echo clocks that are taken directly from the input clock pair. The default depth is kept small so that the model elaborates and simulates quickly.

Top module: `qdr_sram_model`

## Requirements
- R1: A read is accepted when `rps_ni` is low at a rising edge of `clk_k_i` and no read burst is still in its first cycle (in burst-of-four operation the read port is busy for the cycle after an accepted read). Reads can be spaced `BURST/2` cycles apart.
- R2: A write is accepted when `wps_ni` is low at a rising edge of `clk_k_i`, under the same busy rule. The write port works independently of the read port, and both may be accepted in the same cycle.
- R3: For a write accepted in cycle c, beat 2k is taken from `d_i` at the rising edge of `clk_k_i` in cycle c+k. Beat 2k+1 is taken at the rising edge of `clk_kb_i` in cycle c+k. Beat j is stored at word index `addr*BURST + j`.
- R4: For a read accepted in cycle c, beat 2k of word index `addr*BURST + 2k` drives `q_o` while `clk_k_i` is high in cycle c+RD_LAT+k. Beat 2k+1 drives `q_o` while `clk_k_i` is low in the same cycle.
- R5: `qvld_o` is high in exactly the `BURST` half-cycles that carry read beats and low in every other half-cycle.
- R6: Byte enable bit i of `bws_ni`, sampled with each beat, leaves bits [9i+8:9i] of the stored word unchanged when it is high, and writes them when it is low.
- R7: A write is committed at the `clk_kb_i` edge of its last data beat. A read accepted in any cycle from c to c+BURST/2-1, where c is the write's command cycle, returns the old data. A read accepted later returns the new data.
- R8: `cq_o` follows `clk_k_i` and `cq_n_o` follows `clk_kb_i`.
- R9: In burst-of-four operation, a command presented on a port during that port's busy cycle is ignored. The memory and the output stream are unaffected by it.
- R10: Reads accepted every `BURST/2` cycles give an unbroken `qvld_o` with no beats lost or repeated.
- R11: While `rst_ni` is low, and after it is released until the first read beat, `qvld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k_i | input | 1 | Main clock; commands and even beats are sampled on its rising edge |
| clk_kb_i | input | 1 | Complementary clock; odd write beats are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the control state |
| rps_ni | input | 1 | Read command, active low |
| rd_addr_i | input | log2(DEPTH/BURST) | Read burst address |
| wps_ni | input | 1 | Write command, active low |
| wr_addr_i | input | log2(DEPTH/BURST) | Write burst address |
| d_i | input | DATA_W | Write data, one beat per clock edge |
| bws_ni | input | DATA_W/9 | Active-low byte enables for the current write beat |
| q_o | output | DATA_W | Read data, one beat per half-cycle |
| qvld_o | output | 1 | High in half-cycles that carry read data |
| cq_o | output | 1 | Echo clock following clk_k_i |
| cq_n_o | output | 1 | Echo clock following clk_kb_i |

## Verification
First, a fill pass writes every burst address with distinct random words. A back-to-back read-out at the minimum spacing then confirms that bank routing and beat order are correct and that the valid strobe never breaks. A read that shares its cycle with a write to the same address, and a read placed one cycle after such a write, separate old-data from new-data ordering. Masked writes with alternating byte enables show lane isolation. Commands held low through a busy cycle confirm that the second command is dropped on both ports. A long random mix of overlapping reads and writes, checked every half-cycle against a behavioural model, finds errors in the busy accounting and in the read and write ordering.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int unsigned BYTE_W = 9;

  function automatic int unsigned cnt_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/qdr_bank_array.sv
module qdr_bank_array import qdr_pkg::*; #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned BURST  = 4,
  parameter int unsigned AW     = 6
) (
  input  logic                           clk_kb_i,
  input  logic                           we_i,
  input  logic [AW-1:0]                  waddr_i,
  input  logic [BURST-1:0][DATA_W-1:0]   wdata_i,
  input  logic [BURST-1:0][DATA_W/BYTE_W-1:0] wbe_ni,
  input  logic [AW-1:0]                  raddr_i,
  output logic [BURST-1:0][DATA_W-1:0]   rdata_o
);
  localparam int unsigned NB         = DATA_W / BYTE_W;
  localparam int unsigned BANK_DEPTH = 2 ** AW;

  // one bank per beat position, all indexed by the burst address
  for (genvar b = 0; b < BURST; b++) begin : g_bank
    logic [DATA_W-1:0] mem [BANK_DEPTH];

    always_ff @(posedge clk_kb_i) begin
      if (we_i) begin
        for (int k = 0; k < NB; k++) begin
          if (!wbe_ni[b][k]) mem[waddr_i][k*BYTE_W +: BYTE_W] <= wdata_i[b][k*BYTE_W +: BYTE_W];
        end
      end
    end

    assign rdata_o[b] = mem[raddr_i];
  end
endmodule

// File: rtl/qdr_wr_port.sv
module qdr_wr_port import qdr_pkg::*; #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned BURST  = 4,
  parameter int unsigned AW     = 6
) (
  input  logic                           clk_k_i,
  input  logic                           clk_kb_i,
  input  logic                           rst_ni,
  input  logic                           wps_ni,
  input  logic [AW-1:0]                  wr_addr_i,
  input  logic [DATA_W-1:0]              d_i,
  input  logic [DATA_W/BYTE_W-1:0]       bws_ni,
  output logic                           we_o,
  output logic [AW-1:0]                  waddr_o,
  output logic [BURST-1:0][DATA_W-1:0]   wdata_o,
  output logic [BURST-1:0][DATA_W/BYTE_W-1:0] wbe_no
);
  localparam int unsigned NB   = DATA_W / BYTE_W;
  localparam int unsigned HALF = BURST / 2;
  localparam int unsigned CW   = cnt_w(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic          w_act;
  logic [CW-1:0] w_cyc;
  logic [AW-1:0] w_addr;
  logic          busy, accept;

  logic [DATA_W-1:0] ev_d [HALF];
  logic [DATA_W-1:0] od_d [HALF];
  logic [NB-1:0]     ev_b [HALF];
  logic [NB-1:0]     od_b [HALF];

  assign busy   = w_act && (w_cyc != LAST);
  assign accept = !wps_ni && !busy;

  always_ff @(posedge clk_k_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_act  <= 1'b0;
      w_cyc  <= '0;
      w_addr <= '0;
    end else if (accept) begin
      w_act  <= 1'b1;
      w_cyc  <= '0;
      w_addr <= wr_addr_i;
    end else if (busy) begin
      w_cyc  <= w_cyc + 1'b1;
    end else begin
      w_act  <= 1'b0;
    end
  end

  // even beats on the main clock
  always_ff @(posedge clk_k_i) begin
    if (accept) begin
      ev_d[0] <= d_i;
      ev_b[0] <= bws_ni;
    end else if (busy) begin
      ev_d[w_cyc + 1'b1] <= d_i;
      ev_b[w_cyc + 1'b1] <= bws_ni;
    end
  end

  // odd beats on the complementary clock
  always_ff @(posedge clk_kb_i) begin
    if (w_act) begin
      od_d[w_cyc] <= d_i;
      od_b[w_cyc] <= bws_ni;
    end
  end

  // commit happens at the complementary edge carrying the final beat
  assign we_o    = w_act && (w_cyc == LAST);
  assign waddr_o = w_addr;

  for (genvar j = 0; j < HALF; j++) begin : g_beat
    assign wdata_o[2*j] = ev_d[j];
    assign wbe_no[2*j]  = ev_b[j];
    if (j == HALF - 1) begin : g_tail
      assign wdata_o[2*j+1] = d_i;
      assign wbe_no[2*j+1]  = bws_ni;
    end else begin : g_mid
      assign wdata_o[2*j+1] = od_d[j];
      assign wbe_no[2*j+1]  = od_b[j];
    end
  end

  AST_WR_BUSY_DROP: assert property (@(posedge clk_k_i) disable iff (!rst_ni)
    (accept && BURST == 4) |=> !accept); // R9

  AST_WR_ADDR_HOLD: assert property (@(posedge clk_k_i) disable iff (!rst_ni)
    (w_act && w_cyc != LAST) |=> $stable(w_addr)); // R3
endmodule

// File: rtl/qdr_rd_port.sv
module qdr_rd_port import qdr_pkg::*; #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned BURST  = 4,
  parameter int unsigned RD_LAT = 2
) (
  input  logic                         clk_k_i,
  input  logic                         clk_kb_i,
  input  logic                         rst_ni,
  input  logic                         rps_ni,
  input  logic [BURST-1:0][DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0]            q_o,
  output logic                         qvld_o
);
  localparam int unsigned HALF = BURST / 2;
  localparam int unsigned CW   = cnt_w(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic          r_act;
  logic [CW-1:0] r_cyc;
  logic          busy, accept;

  logic [RD_LAT-1:0]               pv;
  logic [BURST-1:0][DATA_W-1:0]    pd [RD_LAT];
  logic [BURST-1:0][DATA_W-1:0]    o_buf;
  logic                            o_act;
  logic [CW-1:0]                   o_cyc;
  logic [DATA_W-1:0]               ob_ev [HALF];
  logic [DATA_W-1:0]               ob_od [HALF];
  logic [DATA_W-1:0]               qb;
  logic                            vb;

  assign busy   = r_act && (r_cyc != LAST);
  assign accept = !rps_ni && !busy;

  always_ff @(posedge clk_k_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_act <= 1'b0;
      r_cyc <= '0;
      pv    <= '0;
      o_act <= 1'b0;
      o_cyc <= '0;
    end else begin
      if (accept) begin
        r_act <= 1'b1;
        r_cyc <= '0;
      end else if (busy) begin
        r_cyc <= r_cyc + 1'b1;
      end else begin
        r_act <= 1'b0;
      end
      pv[0] <= accept;
      for (int i = 1; i < RD_LAT; i++) pv[i] <= pv[i-1];
      if (pv[RD_LAT-1]) begin
        o_act <= 1'b1;
        o_cyc <= '0;
      end else if (o_act && o_cyc != LAST) begin
        o_cyc <= o_cyc + 1'b1;
      end else begin
        o_act <= 1'b0;
      end
    end
  end

  // burst snapshot taken at command edge, ahead of any same-cycle commit
  always_ff @(posedge clk_k_i) begin
    pd[0] <= rdata_i;
    for (int i = 1; i < RD_LAT; i++) pd[i] <= pd[i-1];
    if (pv[RD_LAT-1]) o_buf <= pd[RD_LAT-1];
  end

  for (genvar j = 0; j < HALF; j++) begin : g_view
    assign ob_ev[j] = o_buf[2*j];
    assign ob_od[j] = o_buf[2*j+1];
  end

  always_ff @(posedge clk_kb_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vb <= 1'b0;
      qb <= '0;
    end else begin
      vb <= o_act;
      qb <= ob_od[o_cyc];
    end
  end

  // double-rate output: high phase shows even beat, low phase odd beat
  assign q_o    = clk_k_i ? ob_ev[o_cyc] : qb;
  assign qvld_o = clk_k_i ? o_act : vb;

  AST_RD_BUSY_DROP: assert property (@(posedge clk_k_i) disable iff (!rst_ni)
    (accept && BURST == 4) |=> !accept); // R9

  AST_VLD_NO_GAP: assert property (@(posedge clk_k_i) disable iff (!rst_ni)
    (o_act && o_cyc != LAST) |=> o_act); // R5

  AST_NO_OVERLAP: assert property (@(posedge clk_k_i) disable iff (!rst_ni)
    pv[RD_LAT-1] |-> (!o_act || o_cyc == LAST)); // R10
endmodule

// File: rtl/qdr_sram_model.sv
module qdr_sram_model import qdr_pkg::*; #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned BURST  = 4,
  parameter int unsigned RD_LAT = 2
) (
  input  logic                              clk_k_i,
  input  logic                              clk_kb_i,
  input  logic                              rst_ni,
  input  logic                              rps_ni,
  input  logic [$clog2(DEPTH/BURST)-1:0]    rd_addr_i,
  input  logic                              wps_ni,
  input  logic [$clog2(DEPTH/BURST)-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]                 d_i,
  input  logic [DATA_W/BYTE_W-1:0]          bws_ni,
  output logic [DATA_W-1:0]                 q_o,
  output logic                              qvld_o,
  output logic                              cq_o,
  output logic                              cq_n_o
);
  localparam int unsigned AW = $clog2(DEPTH / BURST);
  localparam int unsigned NB = DATA_W / BYTE_W;

  logic                         we;
  logic [AW-1:0]                waddr;
  logic [BURST-1:0][DATA_W-1:0] wdata;
  logic [BURST-1:0][NB-1:0]     wbe_n;
  logic [BURST-1:0][DATA_W-1:0] rdata;

  qdr_wr_port #(.DATA_W(DATA_W), .BURST(BURST), .AW(AW)) i_wr (
    .clk_k_i, .clk_kb_i, .rst_ni, .wps_ni, .wr_addr_i, .d_i, .bws_ni,
    .we_o(we), .waddr_o(waddr), .wdata_o(wdata), .wbe_no(wbe_n)
  );

  qdr_bank_array #(.DATA_W(DATA_W), .BURST(BURST), .AW(AW)) i_mem (
    .clk_kb_i, .we_i(we), .waddr_i(waddr), .wdata_i(wdata), .wbe_ni(wbe_n),
    .raddr_i(rd_addr_i), .rdata_o(rdata)
  );

  qdr_rd_port #(.DATA_W(DATA_W), .BURST(BURST), .RD_LAT(RD_LAT)) i_rd (
    .clk_k_i, .clk_kb_i, .rst_ni, .rps_ni, .rdata_i(rdata), .q_o, .qvld_o
  );

  // echo clocks taken straight from the input pair
  assign cq_o   = clk_k_i;
  assign cq_n_o = clk_kb_i;
endmodule

// File: tb/test_qdr_sram_model.sv
module test_qdr_sram_model;
  localparam int DW = 18, DEPTH = 256, BURST = 4, LAT = 2;
  localparam int NB = DW / 9, AW = $clog2(DEPTH / BURST), HALF = BURST / 2, NA = DEPTH / BURST;

  logic clk_k = 1'b0;
  logic clk_kb;
  logic rst_ni = 1'b0;
  logic rps_n = 1'b1, wps_n = 1'b1;
  logic [AW-1:0] ra = '0, wa = '0;
  logic [DW-1:0] d = '0;
  logic [NB-1:0] bws = '1;
  logic [DW-1:0] q;
  logic qvld, cq, cq_n;

  always #2.5 clk_k = ~clk_k;
  assign clk_kb = ~clk_k;

  qdr_sram_model #(.DATA_W(DW), .DEPTH(DEPTH), .BURST(BURST), .RD_LAT(LAT)) i_qdr_sram_model (
    .clk_k_i(clk_k), .clk_kb_i(clk_kb), .rst_ni, .rps_ni(rps_n), .rd_addr_i(ra),
    .wps_ni(wps_n), .wr_addr_i(wa), .d_i(d), .bws_ni(bws),
    .q_o(q), .qvld_o(qvld), .cq_o(cq), .cq_n_o(cq_n)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  string tag = "R11";

  // reference state
  logic [DW-1:0] rmem [DEPTH];
  bit            ev [int];
  logic [DW-1:0] ed [int];
  bit r_act = 0; int r_k = 0;
  bit w_act = 0; int w_k = 0; int w_base = 0;
  logic [DW-1:0] wb_d [BURST];
  logic [NB-1:0] wb_m [BURST];

  task automatic check(bit ok, string t, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", t, cyc, act, exp);
    end
  endtask

  task automatic model(bit rd, int radr, bit wr, int wadr,
                       logic [DW-1:0] d0, logic [NB-1:0] m0, logic [DW-1:0] d1, logic [NB-1:0] m1);
    bit rbusy, wbusy;
    rbusy = r_act && (r_k < HALF - 1);
    if (rd && !rbusy) begin
      r_act = 1; r_k = 0;
      for (int j = 0; j < BURST; j++) begin
        int key = 2 * (cyc + LAT + j / 2) + (j % 2);
        ev[key] = 1;
        ed[key] = rmem[radr * BURST + j];
      end
    end else if (rbusy) r_k++;
    else r_act = 0;
    wbusy = w_act && (w_k < HALF - 1);
    if (wr && !wbusy) begin
      w_act = 1; w_k = 0; w_base = wadr;
    end else if (wbusy) w_k++;
    else w_act = 0;
    if (w_act) begin
      wb_d[2*w_k] = d0; wb_m[2*w_k] = m0;
      wb_d[2*w_k+1] = d1; wb_m[2*w_k+1] = m1;
      if (w_k == HALF - 1) begin
        for (int j = 0; j < BURST; j++)
          for (int b = 0; b < NB; b++)
            if (!wb_m[j][b]) rmem[w_base * BURST + j][b*9 +: 9] = wb_d[j][b*9 +: 9];
      end
    end
  endtask

  task automatic sample(int h);
    int key = 2 * cyc + h;
    bit expv = ev.exists(key);
    check(qvld === expv, "R5 valid", {17'b0, qvld}, {17'b0, expv});
    if (expv) check(q === ed[key], tag, q, ed[key]);
    check(cq === (h == 0) && cq_n === (h != 0), "R8 echo", {17'b0, cq}, {17'b0, (h == 0)});
  endtask

  task automatic step(bit rd, int radr, bit wr, int wadr,
                      logic [DW-1:0] d0, logic [NB-1:0] m0, logic [DW-1:0] d1, logic [NB-1:0] m1);
    rps_n = !rd; ra = AW'(radr); wps_n = !wr; wa = AW'(wadr); d = d0; bws = m0;
    @(posedge clk_k);
    model(rd, radr, wr, wadr, d0, m0, d1, m1);
    #1.25; sample(0);
    d = d1; bws = m1;
    #2.5; sample(1);
    cyc++;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, '1, '0, '1);
  endtask

  function automatic logic [DW-1:0] rnd();
    return DW'($urandom);
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R11: valid low while in reset
    repeat (3) @(posedge clk_k);
    #1.25 check(qvld === 1'b0, "R11 reset", {17'b0, qvld}, '0);
    #2.5  check(qvld === 1'b0, "R11 reset", {17'b0, qvld}, '0);
    rst_ni = 1'b1;
    idle(3);

    tag = "R3 fill";
    for (int a = 0; a < NA; a++) begin
      step(0, 0, 1, a, rnd(), '0, rnd(), '0);
      step(0, 0, 0, 0, rnd(), '0, rnd(), '0);
    end

    tag = "R4/R10 readout";
    for (int a = 0; a < NA; a++) begin
      step(1, a, 0, 0, '0, '1, '0, '1);
      step(0, 0, 0, 0, '0, '1, '0, '1);
    end
    idle(4);

    tag = "R1 isolated";
    step(1, 3, 0, 0, '0, '1, '0, '1); idle(3);
    step(1, 60, 0, 0, '0, '1, '0, '1); idle(4);

    tag = "R7 order";
    step(1, 5, 1, 5, rnd(), '0, rnd(), '0);
    step(0, 0, 0, 0, rnd(), '0, rnd(), '0);
    step(1, 5, 0, 0, '0, '1, '0, '1); idle(4);
    step(0, 0, 1, 7, rnd(), '0, rnd(), '0);
    step(1, 7, 0, 0, rnd(), '0, rnd(), '0);
    step(0, 0, 0, 0, '0, '1, '0, '1);
    step(1, 7, 0, 0, '0, '1, '0, '1); idle(4);

    tag = "R6 mask";
    step(0, 0, 1, 9, rnd(), 2'b01, rnd(), 2'b10);
    step(0, 0, 0, 0, rnd(), 2'b11, rnd(), 2'b00);
    step(0, 0, 1, 10, rnd(), 2'b11, rnd(), 2'b11);
    step(0, 0, 0, 0, rnd(), 2'b11, rnd(), 2'b11);
    step(1, 9, 0, 0, '0, '1, '0, '1); idle(1);
    step(1, 10, 0, 0, '0, '1, '0, '1); idle(4);

    tag = "R9 busy drop";
    step(1, 11, 1, 12, rnd(), '0, rnd(), '0);
    step(1, 20, 1, 21, rnd(), '0, rnd(), '0);
    idle(4);
    step(1, 21, 0, 0, '0, '1, '0, '1); idle(1);
    step(1, 12, 0, 0, '0, '1, '0, '1); idle(1);
    step(1, 20, 0, 0, '0, '1, '0, '1); idle(4);

    tag = "R2 mixed";
    for (int i = 0; i < 400; i++)
      step(($urandom % 2) == 1, $urandom % NA, ($urandom % 2) == 1, $urandom % NA,
           rnd(), NB'($urandom), rnd(), NB'($urandom));
    idle(6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule